// File: doc/BRIEF.md
# Serial-Port Sample Rate Generator

This block derives a divided bit clock (`clkg`) and a frame strobe (`fsg`) for the transmit and receive halves of a buffered serial port. The input clock is one of three sources: a peripheral clock enable from inside the chip, a receive-side clock pin or a transmit-side clock pin. The two pins are sampled on the system clock, and each synchronized rising edge counts as one input clock edge. A small write-only register set holds the divider, the frame period and a control word. The control word selects the source and turns on a resynchronization mode.

In free-running mode `clkg` spans DIV+1 input edges and `fsg` repeats every FPER+1 periods of `clkg`. When resynchronization is on and a pin is the source, a rising edge on the frame-sync pin restarts the `clkg` phase and fires `fsg` at once. In that mode the programmed frame period plays no part. New settings are held in shadow registers and move into the working set only at a frame boundary, so no output pulse is ever cut short. An illegal source code stops both outputs and sets a sticky error flag.

Top module: `srate_gen`

## Requirements
- R1: During reset `clkg`, `fsg` and `cfg_err` are 0. The reset configuration is internal source, DIV 0, FPER 0 and resync off. With `pclk_en` held high, both `clkg` and `fsg` then stay high.
- R2: Control bits [1:0] pick the source. 01 selects the `pclk_en` strobe (one edge per cycle in which it is high). 10 selects the synchronized rising edges of `rclk_pin`. 11 selects the synchronized rising edges of `xclk_pin`.
- R3: For DIV above 0, one `clkg` period spans DIV+1 input edges and `clkg` is high for the first ceil((DIV+1)/2) of them. For DIV 0, `clkg` is high for one system cycle per input edge.
- R4: In free-running mode `fsg` rises together with a `clkg` rising edge, once every FPER+1 `clkg` periods, and stays high for one `clkg` period.
- R5: Values written to the divider, frame-period or control registers do not affect the outputs until the next frame boundary, which is the `clkg` period in which `fsg` rises.
- R6: The resync bit (control bit 2) has no effect while the internal source is selected.
- R7: With resync on and a pin as the source, `fsg` rises only in response to a rising edge on `fs_pin`, and FPER has no effect.
- R8: In resync mode, `fsg` and `clkg` are both high after the third system clock edge that follows the rise of `fs_pin`, and `fsg` is still low after the second such edge.
- R9: Writing 00 to control bits [1:0] sets `cfg_err` on the next edge. The flag then stays set until reset. Once the code 00 is in effect, `clkg` and `fsg` are held low. A later write of a legal code takes effect on the next cycle, without waiting for a boundary.
- R10: Register map on `cfg_addr`: 0 holds DIV in bits [7:0], 1 holds FPER in bits [11:0], and 2 holds the control word (source in bits [1:0], resync in bit 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pclk_en | input | 1 | Internal peripheral clock strobe |
| rclk_pin | input | 1 | Receive-side external clock pin (asynchronous) |
| xclk_pin | input | 1 | Transmit-side external clock pin (asynchronous) |
| fs_pin | input | 1 | External frame-sync pin (asynchronous) |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select |
| cfg_wdata | input | 12 | Register write data |
| clkg | output | 1 | Divided bit clock |
| fsg | output | 1 | Frame strobe |
| cfg_err | output | 1 | Sticky illegal-source flag |

## Verification
The assertions assume that every pin level lasts at least three system cycles, so each pin rise is seen exactly once after the synchronizer. They also assume that only the three mapped addresses are written. The stimulus toggles the external clocks every three and four cycles and holds the frame-sync pin high for several cycles. It changes every input on the falling clock edge. Timing checks are made only after the active configuration has had a full boundary to settle.

// File: rtl/srate_pkg.sv
package srate_pkg;

    localparam int DIV_W       = 8;
    localparam int FPER_W      = 12;
    localparam int ADDR_W      = 2;
    localparam int SYNC_STAGES = 2;
    localparam int NUM_PINS    = 3;

    localparam int PIN_R  = 0;
    localparam int PIN_X  = 1;
    localparam int PIN_FS = 2;

    typedef enum logic [1:0] {
        SRC_RSVD = 2'b00,
        SRC_INT  = 2'b01,
        SRC_RPIN = 2'b10,
        SRC_XPIN = 2'b11
    } src_e;

    localparam logic [ADDR_W-1:0] REG_DIV  = 2'd0;
    localparam logic [ADDR_W-1:0] REG_FPER = 2'd1;
    localparam logic [ADDR_W-1:0] REG_CTRL = 2'd2;

    typedef struct packed {
        logic              sync_en;
        src_e              src;
        logic [DIV_W-1:0]  div;
        logic [FPER_W-1:0] fper;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{sync_en: 1'b0, src: SRC_INT, div: '0, fper: '0};

endpackage

// File: rtl/srate_edge_sync.sv
module srate_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    // STAGES flops of synchronizer plus one history flop for edge detection
    logic [STAGES:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-1:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];

endmodule

// File: rtl/srate_cfg.sv
module srate_cfg
    import srate_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [FPER_W-1:0] wdata,
    input  logic              load,
    output cfg_t              act,
    output logic              err
);
    typedef struct packed {
        cfg_t shadow;
        cfg_t active;
        logic err;
    } cfg_state_t;

    localparam cfg_state_t ST_RESET = '{shadow: CFG_RESET, active: CFG_RESET, err: 1'b0};

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr) begin
            case (addr)
                REG_DIV:  st_d.shadow.div  = wdata[DIV_W-1:0];
                REG_FPER: st_d.shadow.fper = wdata;
                REG_CTRL: begin
                    st_d.shadow.src     = src_e'(wdata[1:0]);
                    st_d.shadow.sync_en = wdata[2];
                    if (wdata[1:0] == SRC_RSVD) st_d.err = 1'b1;
                end
                default: ;
            endcase
        end
        // working set moves only at a frame boundary
        if (load) st_d.active = st_q.shadow;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RESET;
        else        st_q <= st_d;
    end

    assign act = st_q.active;
    assign err = st_q.err;

endmodule

// File: rtl/srate_core.sv
module srate_core
    import srate_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              resync,
    input  logic              sync_mode,
    input  logic              rsvd,
    input  logic [DIV_W-1:0]  div,
    input  logic [FPER_W-1:0] fper,
    output logic              clkg,
    output logic              fsg,
    output logic              boundary
);
    localparam int HL_W = DIV_W + 1;

    typedef struct packed {
        logic [DIV_W-1:0]  cnt;
        logic [FPER_W-1:0] fcnt;
        logic              clkg;
        logic              fsg;
    } core_state_t;

    core_state_t st_d, st_q;
    logic [HL_W-1:0] high_len;
    logic [HL_W-1:0] cnt_inc;

    always_comb begin
        high_len = ({1'b0, div} + HL_W'(2)) >> 1;
        cnt_inc  = {1'b0, st_q.cnt} + HL_W'(1);
        st_d     = st_q;
        boundary = 1'b0;
        if (rsvd) begin
            st_d     = '0;
            boundary = 1'b1;
        end else if (resync) begin
            st_d.cnt  = '0;
            st_d.fcnt = '0;
            st_d.clkg = 1'b1;
            st_d.fsg  = 1'b1;
            boundary  = 1'b1;
        end else if (tick) begin
            if (st_q.cnt >= div) begin
                st_d.cnt  = '0;
                st_d.clkg = 1'b1;
                if (sync_mode) begin
                    st_d.fsg = 1'b0;
                end else if (st_q.fcnt >= fper) begin
                    st_d.fcnt = '0;
                    st_d.fsg  = 1'b1;
                    boundary  = 1'b1;
                end else begin
                    st_d.fcnt = st_q.fcnt + 1'b1;
                    st_d.fsg  = 1'b0;
                end
            end else begin
                st_d.cnt  = cnt_inc[DIV_W-1:0];
                st_d.clkg = (cnt_inc < high_len);
            end
        end else if (div == '0) begin
            st_d.clkg = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign clkg = st_q.clkg;
    assign fsg  = st_q.fsg;

endmodule

// File: rtl/srate_gen.sv
module srate_gen
    import srate_pkg::*;
#(
    parameter int STAGES = SYNC_STAGES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pclk_en,
    input  logic              rclk_pin,
    input  logic              xclk_pin,
    input  logic              fs_pin,
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [FPER_W-1:0] cfg_wdata,
    output logic              clkg,
    output logic              fsg,
    output logic              cfg_err
);
    logic [NUM_PINS-1:0] pins;
    logic [NUM_PINS-1:0] pin_rise;
    cfg_t act;
    logic tick, fs_rise, sync_mode, act_rsvd, boundary;

    assign pins = {fs_pin, xclk_pin, rclk_pin};

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        srate_edge_sync #(.STAGES(STAGES)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (pins[g]),
            .rise (pin_rise[g])
        );
    end

    srate_cfg u_cfg (
        .clk  (clk),
        .rst_n(rst_n),
        .wr   (cfg_wr),
        .addr (cfg_addr),
        .wdata(cfg_wdata),
        .load (boundary),
        .act  (act),
        .err  (cfg_err)
    );

    always_comb begin
        case (act.src)
            SRC_INT:  tick = pclk_en;
            SRC_RPIN: tick = pin_rise[PIN_R];
            SRC_XPIN: tick = pin_rise[PIN_X];
            default:  tick = 1'b0;
        endcase
    end

    assign fs_rise   = pin_rise[PIN_FS];
    assign act_rsvd  = (act.src == SRC_RSVD);
    assign sync_mode = act.sync_en && (act.src == SRC_RPIN || act.src == SRC_XPIN);

    srate_core u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .resync   (sync_mode && fs_rise),
        .sync_mode(sync_mode),
        .rsvd     (act_rsvd),
        .div      (act.div),
        .fper     (act.fper),
        .clkg     (clkg),
        .fsg      (fsg),
        .boundary (boundary)
    );

endmodule

// File: rtl/srate_gen_chk.sv
module srate_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_wr,
    input logic clkg,
    input logic fsg,
    input logic cfg_err,
    input logic act_rsvd,
    input logic sync_mode,
    input logic fs_rise,
    input logic tick
);
    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);

    // R9
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_err) |-> $past(cfg_wr));

    // R9
    rsvd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_rsvd && $past(act_rsvd)) |-> (!clkg && !fsg));

    // R4
    fsg_with_clkg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fsg) |-> clkg);

    // R7
    sync_fsg_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(fsg) && $past(sync_mode)) |-> $past(fs_rise));

    // R3
    clkg_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clkg) |-> ($past(tick) || $past(fs_rise && sync_mode)));

endmodule

bind srate_gen srate_gen_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_wr   (cfg_wr),
    .clkg     (clkg),
    .fsg      (fsg),
    .cfg_err  (cfg_err),
    .act_rsvd (act_rsvd),
    .sync_mode(sync_mode),
    .fs_rise  (fs_rise),
    .tick     (tick)
);

// File: tb/srate_gen_tb.sv
module srate_gen_tb;
    import srate_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pclk_en = 1'b1;
    logic rclk_pin = 1'b0;
    logic xclk_pin = 1'b0;
    logic fs_pin = 1'b0;
    logic cfg_wr = 1'b0;
    logic [ADDR_W-1:0] cfg_addr = '0;
    logic [FPER_W-1:0] cfg_wdata = '0;
    logic clkg, fsg, cfg_err;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    string tag_q[$];
    int    exp_q[$];

    srate_gen u_dut (
        .clk(clk), .rst_n(rst_n), .pclk_en(pclk_en), .rclk_pin(rclk_pin),
        .xclk_pin(xclk_pin), .fs_pin(fs_pin), .cfg_wr(cfg_wr),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .clkg(clkg), .fsg(fsg), .cfg_err(cfg_err)
    );

    always #5 clk = ~clk;
    // external clocks change on falling system edges: 6 and 8 cycle periods
    initial forever #30 rclk_pin = ~rclk_pin;
    initial forever #40 xclk_pin = ~xclk_pin;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // driver side: expected items
    task automatic push_exp(input string t, input int v);
        tag_q.push_back(t);
        exp_q.push_back(v);
    endtask

    // monitor side: compare an observed result with the oldest expectation
    task automatic score(input int act);
        string t;
        int e;
        if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL scoreboard-empty actual=%0d expected=none", act);
            return;
        end
        t = tag_q.pop_front();
        e = exp_q.pop_front();
        checks++;
        if (act !== e) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", t, act, e);
        end
    endtask

    task automatic chk(input string t, input logic act, input logic e);
        push_exp(t, int'(e));
        score(int'(act));
    endtask

    function automatic logic pick(input int w);
        return (w == 0) ? clkg : fsg;
    endfunction

    // measure high time and period of the next full pulse of clkg (0) or fsg (1)
    task automatic meas(input int w, output int hi, output int per);
        int n;
        n = 0;
        while (pick(w) !== 1'b0 && n < 400) begin @(negedge clk); n++; end
        n = 0;
        while (pick(w) !== 1'b1 && n < 400) begin @(negedge clk); n++; end
        hi = 0;
        while (pick(w) === 1'b1 && hi < 400) begin @(negedge clk); hi++; end
        per = hi;
        while (pick(w) === 1'b0 && per < 800) begin @(negedge clk); per++; end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input int d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d[FPER_W-1:0];
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic run_pair(input int w, input string t, input int eper, input int ehi);
        int hi, per;
        push_exp({t, " period"}, eper);
        push_exp({t, " high"}, ehi);
        meas(w, hi, per);
        score(per);
        score(hi);
    endtask

    initial begin
        int n, bad, rises;
        logic seen_low, prev;

        repeat (3) @(negedge clk);
        chk("R1 reset clkg", clkg, 1'b0);
        chk("R1 reset fsg", fsg, 1'b0);
        chk("R1 reset err", cfg_err, 1'b0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R1 default clkg", clkg, 1'b1);
        chk("R1 default fsg", fsg, 1'b1);

        // R10 register map: div at 0, fper at 1
        wr(REG_DIV, 3);
        wr(REG_FPER, 2);
        repeat (40) @(negedge clk);
        run_pair(0, "R3 R10 clkg div3", 4, 2);
        run_pair(1, "R4 fsg fper2", 12, 4);

        // R5: divider change mid-frame waits for the boundary
        n = 0;
        while (fsg !== 1'b0 && n < 100) begin @(negedge clk); n++; end
        n = 0;
        while (fsg !== 1'b1 && n < 100) begin @(negedge clk); n++; end
        n = 0; seen_low = 1'b0;
        do begin
            @(negedge clk); n++;
            if (n == 2) begin cfg_wr = 1'b1; cfg_addr = REG_DIV; cfg_wdata = 12'd1; end
            if (n == 3) cfg_wr = 1'b0;
            if (fsg === 1'b0) seen_low = 1'b1;
        end while (!(seen_low && fsg === 1'b1) && n < 400);
        push_exp("R5 frame after mid-frame write", 12);
        score(n);
        run_pair(1, "R5 fsg new div1", 6, 2);

        // R3 odd divider rounding
        wr(REG_DIV, 4);
        wr(REG_FPER, 1);
        repeat (40) @(negedge clk);
        run_pair(0, "R3 clkg div4", 5, 3);
        run_pair(1, "R4 fsg fper1", 10, 5);

        // R6 resync bit with internal source
        wr(REG_CTRL, 3'b101);
        repeat (40) @(negedge clk);
        run_pair(1, "R6 fsg sync ignored", 10, 5);

        // R9 reserved source
        wr(REG_CTRL, 3'b000);
        chk("R9 err set", cfg_err, 1'b1);
        repeat (30) @(negedge clk);
        bad = 0;
        repeat (20) begin
            @(negedge clk);
            if (clkg !== 1'b0 || fsg !== 1'b0) bad++;
        end
        push_exp("R9 outputs held low", 0);
        score(bad);
        wr(REG_CTRL, 3'b001);
        chk("R9 err sticky", cfg_err, 1'b1);
        repeat (10) @(negedge clk);
        run_pair(0, "R9 clkg resumed", 5, 3);

        // R2 receive pin source
        wr(REG_DIV, 1);
        wr(REG_FPER, 1);
        wr(REG_CTRL, 3'b010);
        repeat (200) @(negedge clk);
        run_pair(0, "R2 clkg rclk", 12, 6);
        run_pair(1, "R4 fsg rclk", 24, 12);

        // R2 transmit pin source
        wr(REG_CTRL, 3'b011);
        repeat (200) @(negedge clk);
        run_pair(0, "R2 clkg xclk", 16, 8);

        // R7 resync mode on receive pin
        wr(REG_CTRL, 3'b110);
        repeat (100) @(negedge clk);
        bad = 0;
        repeat (100) begin
            @(negedge clk);
            if (fsg !== 1'b0) bad++;
        end
        push_exp("R7 no fsg without fs pin", 0);
        score(bad);

        // R8 latency from fs pin
        fs_pin = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R8 fsg low after 2 edges", fsg, 1'b0);
        @(negedge clk);
        chk("R8 fsg high after 3 edges", fsg, 1'b1);
        chk("R8 clkg realigned", clkg, 1'b1);
        repeat (3) @(negedge clk);
        fs_pin = 1'b0;
        rises = 0; prev = fsg;
        repeat (150) begin
            @(negedge clk);
            if (fsg === 1'b1 && prev === 1'b0) rises++;
            prev = fsg;
        end
        push_exp("R7 fper ignored, one strobe per fs", 0);
        score(rises);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule